// File: doc/BRIEF.md
# Alternating Step Keystream Generator

This block produces a pseudorandom keystream, one bit per enabled step, from three linear feedback shift registers. A control register steps on every enabled step. Its current output bit decides which one of two data registers advances in that step. The keystream bit is the XOR of the two data registers' output bits, taken after the chosen register has moved. Because the data registers advance irregularly, the stream is not the output of any single register.

A seed port loads all three registers in parallel in one cycle. After a load, the caller raises the step enable for as many cycles as it needs keystream bits. Each enabled step yields one registered bit on the following cycle, marked by a valid flag. The register lengths, the tap masks and the fill value are parameters that are fixed at build time.

Top module: `asg_keystream`

## Requirements
- R1: After synchronous active-low reset, ks_valid and ks_bit are 0, and all three registers hold the value 1 (only bit 0 set).
- R2: When load is high, the three registers take seed_c, seed_a and seed_b in the same clock edge. Load takes priority over step_en. ks_valid is 0 in the cycle that follows a load.
- R3: A seed field that is all zeros is replaced by the value 1 when it is loaded. The other fields load unchanged.
- R4: Each register is a Fibonacci LFSR whose output is bit 0. On an advance, the register shifts right by one, and the XOR of the bits selected by its tap mask enters the top bit. The masks are 17'h00009 for the control register (17 bits), 11'h005 for data register A (11 bits) and 13'h001B for data register B (13 bits). The control register advances on every enabled step.
- R5: In a step where the control register's current bit 0 is 0, register A advances and register B holds. When that bit is 1, register B advances and register A holds.
- R6: The keystream bit of a step is bit 0 of A XOR bit 0 of B, both taken after that step's advance.
- R7: ks_valid is 1 in the cycle after each clock edge where step_en is high and load is low, and 0 otherwise. Exactly one keystream bit is produced per step.
- R8: While step_en is low, no register moves and ks_bit keeps its last value. The stream resumes exactly where it stopped.
- R9: No register ever holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Parallel seed load strobe |
| seed_c | input | 17 | Seed for the control register |
| seed_a | input | 11 | Seed for data register A |
| seed_b | input | 13 | Seed for data register B |
| step_en | input | 1 | Advance the generator by one step |
| ks_bit | output | 1 | Keystream bit, registered |
| ks_valid | output | 1 | ks_bit holds a new bit from the previous step |

## Verification
A wrong tap, a wrong shift direction or a wrong choice of data register makes the keystream diverge from the reference model within the first few tens of steps. The bench compares every bit, so such a fault shows at once. A control register that fails to advance, or a step that advances both data registers, changes the pattern of which data register moves. That fault shows in the stream within a handful of steps after the first affected step. Faults in load priority, zero-seed substitution or hold while idle appear in the first valid bit after the load, or in a ks_bit that changes during idle cycles.

// File: rtl/asg_pkg.sv
// Package: shared types and default parameters for the alternating step generator.
// Assumes: nothing beyond IEEE 1800-2017.
package asg_pkg;

    // Which data register a control bit selects.
    typedef enum logic {
        PICK_A = 1'b0,
        PICK_B = 1'b1
    } pick_e;

    // Default lengths of the three registers.
    localparam int unsigned CTRL_LEN = 17;
    localparam int unsigned DATA_A_LEN = 11;
    localparam int unsigned DATA_B_LEN = 13;

    // Default Fibonacci tap masks (bit 0 always set, so the step can be inverted).
    localparam logic [CTRL_LEN-1:0]   CTRL_TAPS   = 17'h00009;
    localparam logic [DATA_A_LEN-1:0] DATA_A_TAPS = 11'h005;
    localparam logic [DATA_B_LEN-1:0] DATA_B_TAPS = 13'h001B;

endpackage

// File: rtl/asg_lfsr.sv
// Module: asg_lfsr
// One Fibonacci LFSR with parallel load and an advance strobe.
// The output is bit 0. On an advance, the register shifts right and the
// XOR of the masked bits enters the top bit. A zero seed is replaced by FILL.
// Assumes: TAP_MASK has bit 0 set and FILL is nonzero, so the all-zero state
// can never be reached.
module asg_lfsr #(
    parameter int unsigned     W        = 11,
    parameter logic [W-1:0]    TAP_MASK = 11'h005,
    parameter logic [W-1:0]    FILL     = 11'h001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         adv,
    output logic         out_bit,
    output logic         peek_bit
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_nxt;
    logic [W-1:0] seed_eff;
    logic         fb;

    // Feedback and shifted next state.
    always_comb begin
        fb        = ^(state_q & TAP_MASK);
        state_nxt = {fb, state_q[W-1:1]};
    end

    // Substitute the fill value for an all-zero seed.
    always_comb begin
        seed_eff = (seed == '0) ? FILL : seed;
    end

    // State register: reset, load, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL;
        end else if (load) begin
            state_q <= seed_eff;
        end else if (adv) begin
            state_q <= state_nxt;
        end
    end

    // Current output and the output after this cycle's advance.
    always_comb begin
        out_bit  = state_q[0];
        peek_bit = adv ? state_nxt[0] : state_q[0];
    end

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);                                              // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(state_q));                       // R8

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> state_q[W-2:0] == $past(state_q[W-1:1])); // R4

    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == '0) |=> state_q == FILL);                   // R3

endmodule

// File: rtl/asg_step_ctrl.sv
// Module: asg_step_ctrl
// Decides which registers advance in the current cycle. A step happens when
// step_en is high and load is low. The control register always advances on a
// step, and the control bit picks exactly one data register.
// Assumes: c_bit is the control register's current output bit.
module asg_step_ctrl
    import asg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic load,
    input  logic c_bit,
    output logic fire,
    output logic adv_c,
    output logic adv_a,
    output logic adv_b
);

    pick_e pick;

    // Qualify the step and select a data register.
    always_comb begin
        fire  = step_en & ~load;
        pick  = pick_e'(c_bit);
        adv_c = fire;
        adv_a = fire & (pick == PICK_A);
        adv_b = fire & (pick == PICK_B);
    end

    AST_ONE_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({adv_a, adv_b}));                                   // R5

    AST_B_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_b |-> c_bit);                                            // R5

    AST_NO_STEP_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(adv_a || adv_b || adv_c));                        // R2

endmodule

// File: rtl/asg_out_reg.sv
// Module: asg_out_reg
// Registers the keystream bit and its valid flag. The valid flag follows
// each step by one cycle. The bit holds its value between steps.
// Assumes: a_peek and b_peek are the data outputs after this cycle's advance.
module asg_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic load,
    input  logic a_peek,
    input  logic b_peek,
    output logic ks_bit,
    output logic ks_valid
);

    // Capture one keystream bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_bit   <= 1'b0;
            ks_valid <= 1'b0;
        end else begin
            ks_valid <= fire;
            if (fire) begin
                ks_bit <= a_peek ^ b_peek;
            end
        end
    end

    AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ks_valid);                                          // R7

    AST_NO_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ks_valid);                                         // R2

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(ks_bit));                                  // R8

endmodule

// File: rtl/asg_keystream.sv
// Module: asg_keystream
// Top of the alternating step keystream generator. A control LFSR picks
// which of two data LFSRs advances on each step. The registered output
// is the XOR of the two data outputs after that advance.
// Assumes: seeds are presented together with load. Zero seeds are replaced.
module asg_keystream
    import asg_pkg::*;
#(
    parameter int unsigned              LEN_C  = CTRL_LEN,
    parameter int unsigned              LEN_A  = DATA_A_LEN,
    parameter int unsigned              LEN_B  = DATA_B_LEN,
    parameter logic [LEN_C-1:0]         TAPS_C = CTRL_TAPS,
    parameter logic [LEN_A-1:0]         TAPS_A = DATA_A_TAPS,
    parameter logic [LEN_B-1:0]         TAPS_B = DATA_B_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_C-1:0] seed_c,
    input  logic [LEN_A-1:0] seed_a,
    input  logic [LEN_B-1:0] seed_b,
    input  logic             step_en,
    output logic             ks_bit,
    output logic             ks_valid
);

    localparam logic [LEN_C-1:0] FILL_C = LEN_C'(1);
    localparam logic [LEN_A-1:0] FILL_A = LEN_A'(1);
    localparam logic [LEN_B-1:0] FILL_B = LEN_B'(1);

    logic fire, adv_c, adv_a, adv_b;
    logic c_bit, c_peek;
    logic a_bit, a_peek;
    logic b_bit, b_peek;

    // Control register: steps on every enabled step.
    asg_lfsr #(.W(LEN_C), .TAP_MASK(TAPS_C), .FILL(FILL_C)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_c),
        .adv(adv_c), .out_bit(c_bit), .peek_bit(c_peek)
    );

    // Data register A: advances when the control bit is 0.
    asg_lfsr #(.W(LEN_A), .TAP_MASK(TAPS_A), .FILL(FILL_A)) u_data_a (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_a),
        .adv(adv_a), .out_bit(a_bit), .peek_bit(a_peek)
    );

    // Data register B: advances when the control bit is 1.
    asg_lfsr #(.W(LEN_B), .TAP_MASK(TAPS_B), .FILL(FILL_B)) u_data_b (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_b),
        .adv(adv_b), .out_bit(b_bit), .peek_bit(b_peek)
    );

    // Step decision.
    asg_step_ctrl u_ctrl_dec (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .load(load),
        .c_bit(c_bit), .fire(fire), .adv_c(adv_c), .adv_a(adv_a), .adv_b(adv_b)
    );

    // Output register.
    asg_out_reg u_out (
        .clk(clk), .rst_n(rst_n), .fire(fire), .load(load),
        .a_peek(a_peek), .b_peek(b_peek), .ks_bit(ks_bit), .ks_valid(ks_valid)
    );

    AST_KS_MATCHES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> ks_bit == (a_bit ^ b_bit));                     // R6

    AST_CTRL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        adv_c |=> c_bit == $past(c_peek));                           // R4

endmodule

// File: tb/sim_asg_keystream.sv
`timescale 1ns/1ps
module sim_asg_keystream;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [16:0] seed_c = '0;
    logic [10:0] seed_a = '0;
    logic [12:0] seed_b = '0;
    logic        step_en = 1'b0;
    logic        ks_bit;
    logic        ks_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [16:0] mc;
    logic [10:0] ma;
    logic [12:0] mb;
    logic        exp_bit;

    always #2.5 clk = ~clk;

    asg_keystream u0 (
        .clk(clk), .rst_n(rst_n), .load(load),
        .seed_c(seed_c), .seed_a(seed_a), .seed_b(seed_b),
        .step_en(step_en), .ks_bit(ks_bit), .ks_valid(ks_valid)
    );

    // Reference LFSR step, taken from R4: shift right, masked XOR enters the top bit.
    function automatic logic [16:0] lf(input logic [16:0] s, input logic [16:0] m, input int w);
        logic fb;
        logic [16:0] r;
        fb = ^(s & m);
        r = s >> 1;
        r[w-1] = fb;
        return r;
    endfunction

    // One reference step from R5 and R6.
    task automatic model_step();
        logic c;
        c = mc[0];
        mc = lf(mc, 17'h00009, 17);
        if (!c) ma = 11'(lf({6'd0, ma}, 17'h005, 11));
        else    mb = 13'(lf({4'd0, mb}, 17'h01B, 13));
        exp_bit = ma[0] ^ mb[0];
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_steps(input int n, input string req);
        step_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            model_step();
            @(negedge clk);
            chk(ks_valid, 1'b1, "R7 valid after step");
            chk(ks_bit, exp_bit, req);
        end
        step_en = 1'b0;
    endtask

    // R2, R3: load seeds, apply zero substitution in the model.
    task automatic do_load(input logic [16:0] c, input logic [10:0] a, input logic [12:0] b, input logic with_step);
        seed_c = c; seed_a = a; seed_b = b;
        load = 1'b1; step_en = with_step;
        mc = (c == 0) ? 17'd1 : c;
        ma = (a == 0) ? 11'd1 : a;
        mb = (b == 0) ? 13'd1 : b;
        @(negedge clk);
        load = 1'b0; step_en = 1'b0;
        chk(ks_valid, 1'b0, "R2 no valid after load");
    endtask

    task automatic t_reset();
        mc = 17'd1; ma = 11'd1; mb = 13'd1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ks_valid, 1'b0, "R1 valid after reset");
        chk(ks_bit, 1'b0, "R1 bit after reset");
        run_steps(40, "R1 stream from reset state");
    endtask

    task automatic t_seeds();
        do_load(17'h1A5C3, 11'h6B1, 13'h1F0E, 1'b0);
        run_steps(300, "R6 stream seed one");
        do_load(17'h0F00F, 11'h001, 13'h1555, 1'b0);
        run_steps(300, "R5 stream seed two");
    endtask

    task automatic t_zero_seed();
        do_load(17'h0, 11'h0, 13'h0, 1'b0);
        run_steps(100, "R3 all zero seeds");
        do_load(17'h12345, 11'h2AA, 13'h0, 1'b0);
        run_steps(100, "R3 zero seed for B only");
    endtask

    task automatic t_idle();
        logic last;
        do_load(17'h0BEEF, 11'h3C3, 13'h0ACE, 1'b0);
        for (int k = 0; k < 20; k++) begin
            run_steps(1 + (k % 3), "R8 stream across gaps");
            last = ks_bit;
            for (int j = 0; j < 1 + (k % 4); j++) begin
                @(negedge clk);
                chk(ks_valid, 1'b0, "R7 no valid while idle");
                chk(ks_bit, last, "R8 bit held while idle");
            end
        end
    endtask

    task automatic t_load_priority();
        run_steps(5, "R2 before priority load");
        do_load(17'h1C001, 11'h0F5, 13'h1234, 1'b1);
        run_steps(80, "R2 load wins over step");
    endtask

    task automatic t_long();
        do_load(17'h00001, 11'h400, 13'h1000, 1'b0);
        run_steps(4000, "R9 long run");
    endtask

    initial begin
        t_reset();
        t_seeds();
        t_zero_seed();
        t_idle();
        t_load_priority();
        t_long();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule